// File: doc/BRIEF.md
# Accumulator Field Extraction Unit

This unit turns a 64-bit signed accumulator into a 32-bit result in one of two ways. In shift mode the accumulator is shifted right arithmetically by a 6-bit amount. Rounding can be applied before the shift, and the shifted value is checked against the 32-bit signed range, with saturation available when it does not fit. In position mode a field of (size+1) bits is taken from the accumulator. The top bit of that field sits at a position held in the unit's own control register, and the field is zero-extended into the result. A decrementing variant moves that position down past the field it has just consumed, so a stream of fields can be read out of the accumulator one after another.

The control register holds the position pointer in bits [5:0], an empty-extraction flag in bit 14 and a sticky overflow flag in bit 23. Every other bit is kept as loaded. The surrounding pipeline loads the register directly, issues one request per cycle, and reads the result and the updated control register one clock edge later.

Top module: `acc_field_extract`

## Requirements
- R1: After reset, `result` and `ctl_q` are both zero.
- R2: When `ctl_load` is high, `ctl_q` takes `ctl_din` at the next edge. A request in the same cycle is ignored, so `result` keeps its previous value.
- R3: A shift request (`pos_mode`=0) with `rnd`=0 returns the low 32 bits of `acc` shifted right arithmetically by `amt`, where `amt` runs from 0 to 63. If the shifted value fits in 32 signed bits, bit 23 is unchanged.
- R4: With `rnd`=1 and `amt`>0, 2^(`amt`-1) is added to `acc` before the shift. With `amt`=0 no rounding takes place.
- R5: If the shifted value lies outside the range -2^31 to 2^31-1, bit 23 is set. With `sat`=1 the result is 0x7FFFFFFF for a positive value and 0x80000000 for a negative one. With `sat`=0 the result is truncated to the low 32 bits.
- R6: If the rounding addition turns a positive accumulator negative, bit 23 is set. With `sat`=1 the sum is replaced by 2^63-1 before the shift. With `sat`=0 the wrapped sum is shifted.
- R7: Bit 23 is sticky: only a load clears it. A shift request leaves every other control bit unchanged, including bits [5:0] and bit 14.
- R8: A position request (`pos_mode`=1) uses size = `amt[4:0]` and pos = `ctl_q[5:0]`. When pos >= size, the result is `acc[pos:pos-size]`, zero-extended, and bit 14 is cleared.
- R9: When pos < size, a position request returns 0 and sets bit 14.
- R10: With `dec`=1, a valid position request writes pos-size-1 into bits [5:0], and writes 63 when pos equals size. With `dec`=0, or when the extraction is invalid, bits [5:0] are unchanged.
- R11: A position request never changes bit 23 or any bit other than [5:0] and 14.
- R12: With no request and no load, `result` and `ctl_q` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_load | input | 1 | Load the control register from `ctl_din` |
| ctl_din | input | 32 | Value to load into the control register |
| req | input | 1 | Extraction request |
| pos_mode | input | 1 | 1 selects position mode, 0 selects shift mode |
| dec | input | 1 | In position mode, move the pointer down after a valid extraction |
| rnd | input | 1 | In shift mode, round before shifting |
| sat | input | 1 | In shift mode, saturate on overflow |
| amt | input | 6 | Shift amount in shift mode; bits [4:0] give the size in position mode |
| acc | input | 64 | Accumulator value |
| result | output | 32 | Registered extraction result |
| ctl_q | output | 32 | Control register: pointer [5:0], empty flag 14, overflow flag 23 |

## Verification
The result and the control update for a request, and a control load, are all due at the first rising edge after the inputs are driven. Nothing is delayed by more than that one register stage. The bench drives every input on a falling edge and holds it across one rising edge. It then samples `result` and `ctl_q` on the next falling edge, which is the one cycle where the new value must already be present. Hold behaviour is checked the same way, by sampling one edge after an idle cycle.

// File: rtl/acc_field_extract.sv
module acc_field_extract #(
  parameter int ACC_W  = 64,
  parameter int RES_W  = 32,
  parameter int CTL_W  = 32,
  parameter int AMT_W  = 6,
  parameter int SIZE_W = 5,
  parameter int EMPTY_BIT = 14,
  parameter int OVF_BIT   = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_load,
  input  logic [CTL_W-1:0] ctl_din,
  input  logic             req,
  input  logic             pos_mode,
  input  logic             dec,
  input  logic             rnd,
  input  logic             sat,
  input  logic [AMT_W-1:0] amt,
  input  logic [ACC_W-1:0] acc,
  output logic [RES_W-1:0] result,
  output logic [CTL_W-1:0] ctl_q
);
  localparam int HI_W = ACC_W - RES_W + 1;
  localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [RES_W-1:0] RES_MAX = {1'b0, {(RES_W-1){1'b1}}};
  localparam logic [RES_W-1:0] RES_MIN = {1'b1, {(RES_W-1){1'b0}}};

  // shift path
  logic             do_rnd, rnd_ovf, fit, sh_ovf;
  logic [ACC_W-1:0] half, rsum, pre, shifted;
  logic [RES_W-1:0] sh_res;

  assign do_rnd  = rnd && (amt != '0);
  assign half    = do_rnd ? (ACC_W'(1) << (amt - AMT_W'(1))) : '0;
  assign rsum    = acc + half;
  assign rnd_ovf = do_rnd && !acc[ACC_W-1] && (acc != '0) && rsum[ACC_W-1];
  assign pre     = (rnd_ovf && sat) ? ACC_MAX : rsum;
  assign shifted = ACC_W'($signed(pre) >>> amt);
  assign fit     = (shifted[ACC_W-1:RES_W-1] == '0) || (shifted[ACC_W-1:RES_W-1] == {HI_W{1'b1}});
  assign sh_ovf  = rnd_ovf || !fit;
  assign sh_res  = (sat && !fit) ? (shifted[ACC_W-1] ? RES_MIN : RES_MAX) : shifted[RES_W-1:0];

  // position path
  logic [AMT_W-1:0]  pos, size, low, next_pos;
  logic              valid;
  logic [ACC_W-1:0]  mask, field;
  logic [RES_W-1:0]  pos_res;

  assign pos      = ctl_q[AMT_W-1:0];
  assign size     = AMT_W'(amt[SIZE_W-1:0]);
  assign valid    = pos >= size;
  assign low      = pos - size;
  assign mask     = (ACC_W'(1) << (size + AMT_W'(1))) - ACC_W'(1);
  assign field    = (acc >> low) & mask;
  assign pos_res  = valid ? field[RES_W-1:0] : '0;
  assign next_pos = (dec && valid) ? (low - AMT_W'(1)) : pos;

  logic [CTL_W-1:0] ctl_next;
  always_comb begin
    ctl_next = ctl_q;
    if (pos_mode) begin
      ctl_next[AMT_W-1:0] = next_pos;
      ctl_next[EMPTY_BIT] = !valid;
    end else if (sh_ovf) begin
      ctl_next[OVF_BIT] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      ctl_q  <= '0;
    end else if (ctl_load) begin
      ctl_q <= ctl_din;
    end else if (req) begin
      result <= pos_mode ? pos_res : sh_res;
      ctl_q  <= ctl_next;
    end
  end

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_load |=> (ctl_q == $past(ctl_din)) && $stable(result));

  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[OVF_BIT] && !ctl_load) |=> ctl_q[OVF_BIT]);

  assert_shift_keeps_pos_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ctl_load && !pos_mode) |=> $stable(ctl_q[AMT_W-1:0]) && $stable(ctl_q[EMPTY_BIT]));

  assert_invalid_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ctl_load && pos_mode && (ctl_q[AMT_W-1:0] < AMT_W'(amt[SIZE_W-1:0])))
      |=> (result == '0) && ctl_q[EMPTY_BIT]);

  assert_dec_ptr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ctl_load && pos_mode && dec && (ctl_q[AMT_W-1:0] >= AMT_W'(amt[SIZE_W-1:0])))
      |=> ctl_q[AMT_W-1:0] == AMT_W'($past(ctl_q[AMT_W-1:0]) - AMT_W'($past(amt[SIZE_W-1:0])) - AMT_W'(1)));

  assert_pos_keeps_ovf_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ctl_load && pos_mode) |=> $stable(ctl_q[OVF_BIT]));

  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!req && !ctl_load) |=> $stable(result) && $stable(ctl_q));
endmodule

// File: tb/acc_field_extract_test.sv
module acc_field_extract_test;
  logic        clk = 0, rst_n = 0;
  logic        ctl_load = 0, req = 0, pos_mode = 0, dec = 0, rnd = 0, sat = 0;
  logic [31:0] ctl_din = 0;
  logic [5:0]  amt = 0;
  logic [63:0] acc = 0;
  logic [31:0] result, ctl_q;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  acc_field_extract uut (.clk, .rst_n, .ctl_load, .ctl_din, .req, .pos_mode, .dec,
                         .rnd, .sat, .amt, .acc, .result, .ctl_q);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load_ctl(logic [31:0] v);
    @(negedge clk); ctl_load = 1; ctl_din = v;
    @(negedge clk); ctl_load = 0;
  endtask

  task automatic shift_req(logic [63:0] a, logic [5:0] s, logic r, logic st);
    @(negedge clk); req = 1; pos_mode = 0; acc = a; amt = s; rnd = r; sat = st;
    @(negedge clk); req = 0;
  endtask

  task automatic pos_req(logic [63:0] a, logic [4:0] sz, logic d);
    @(negedge clk); req = 1; pos_mode = 1; dec = d; acc = a; amt = {1'b0, sz};
    @(negedge clk); req = 0; dec = 0;
  endtask

  task automatic t_reset;
    chk("R1 result", result, 0);
    chk("R1 ctl", ctl_q, 0);
  endtask

  task automatic t_load;
    logic [31:0] r0;
    load_ctl(32'h0000_1234);
    chk("R2 load", ctl_q, 32'h0000_1234);
    r0 = result;
    @(negedge clk); ctl_load = 1; ctl_din = 32'h00AB_0005; req = 1; pos_mode = 0;
    acc = 64'h0000_0000_FFFF_0000; amt = 0;
    @(negedge clk); ctl_load = 0; req = 0;
    chk("R2 load wins ctl", ctl_q, 32'h00AB_0005);
    chk("R2 req ignored", result, r0);
  endtask

  task automatic t_shift;
    load_ctl(32'h0000_402A);
    shift_req(64'h0000_0012_3456_7800, 8, 0, 0);
    chk("R3 shift", result, 32'h1234_5678);
    chk("R3 R7 ctl kept", ctl_q, 32'h0000_402A);
    shift_req(64'hFFFF_FFFF_FFFF_FF00, 4, 0, 0);
    chk("R3 neg", result, 32'hFFFF_FFF0);
    shift_req(64'h0000_0000_0000_0018, 4, 1, 0);
    chk("R4 round up", result, 32'h2);
    shift_req(64'h0000_0000_0000_0017, 4, 1, 0);
    chk("R4 round down", result, 32'h1);
    shift_req(64'h0000_0000_0000_0017, 0, 1, 0);
    chk("R4 no round at zero", result, 32'h17);
    chk("R3 no ovf", ctl_q[23], 0);
  endtask

  task automatic t_ovf;
    load_ctl(0);
    shift_req(64'h0000_0001_0000_0005, 0, 0, 0);
    chk("R5 trunc", result, 32'h5);
    chk("R5 flag", ctl_q[23], 1);
    load_ctl(32'h0000_0011);
    shift_req(64'h0000_0004_0000_0000, 1, 0, 1);
    chk("R5 sat pos", result, 32'h7FFF_FFFF);
    chk("R5 R7 other bits", ctl_q, 32'h0080_0011);
    shift_req(64'hFFFF_FFF0_0000_0000, 2, 0, 1);
    chk("R5 sat neg", result, 32'h8000_0000);
    shift_req(64'h0000_0000_0000_0001, 0, 0, 0);
    chk("R7 sticky", ctl_q[23], 1);
    load_ctl(0);
    shift_req(64'h7FFF_FFFF_FFFF_FFFF, 63, 1, 1);
    chk("R6 sat clamp", result, 32'h0);
    chk("R6 flag", ctl_q[23], 1);
    load_ctl(0);
    shift_req(64'h7FFF_FFFF_FFFF_FFFF, 63, 1, 0);
    chk("R6 wrap", result, 32'hFFFF_FFFF);
    chk("R6 flag nosat", ctl_q[23], 1);
  endtask

  task automatic t_pos;
    load_ctl(32'h0080_4000 | 32'd15);
    pos_req(64'h0000_0000_0000_ABCD, 7, 0);
    chk("R8 field", result, 32'h0000_00AB);
    chk("R8 R11 ctl", ctl_q, 32'h0080_000F);
    pos_req(64'h0000_0000_0000_ABCD, 16, 0);
    chk("R9 zero", result, 0);
    chk("R9 R10 R11 ctl", ctl_q, 32'h0080_400F);
    load_ctl(32'd63);
    pos_req(64'hDEAD_BEEF_0000_0000, 31, 0);
    chk("R8 top word", result, 32'hDEAD_BEEF);
  endtask

  task automatic t_dec;
    load_ctl(32'h0100_0000 | 32'd15);
    pos_req(64'h0000_0000_0000_ABCD, 3, 1);
    chk("R10 first", result, 32'hA);
    chk("R10 ptr", ctl_q, 32'h0100_000B);
    pos_req(64'h0000_0000_0000_ABCD, 7, 1);
    chk("R10 second", result, 32'hBC);
    chk("R10 ptr2", ctl_q, 32'h0100_0003);
    pos_req(64'h0000_0000_0000_ABCD, 3, 1);
    chk("R10 last", result, 32'hD);
    chk("R10 wrap 63", ctl_q, 32'h0100_003F);
    load_ctl(32'd2);
    pos_req(64'hFFFF_FFFF_FFFF_FFFF, 5, 1);
    chk("R10 invalid keeps ptr", ctl_q, 32'h0000_4002);
  endtask

  task automatic t_idle;
    logic [31:0] r0, c0;
    r0 = result; c0 = ctl_q;
    @(negedge clk); acc = 64'h1234; amt = 1; pos_mode = 1; dec = 1;
    @(negedge clk); @(negedge clk);
    chk("R12 result hold", result, r0);
    chk("R12 ctl hold", ctl_q, c0);
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_load();
    t_shift();
    t_ovf();
    t_pos();
    t_dec();
    t_idle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule